// File: doc/BRIEF.md
# Output Gating and Fault Supervisor

This block holds the control logic for eight power switch channels. It keeps a copy of the serial command byte, taken when chip select rises, and combines it with two direct PWM pins, a global enable and two supply monitors. The result drives one gate-enable line per channel. A thermal flag on one channel turns off that channel alone, and the channel turns back on by itself once the flag clears.

The same block qualifies the per-channel analog comparator results and turns them into fault bits for serial readback. What counts as a fault depends on the commanded state of the channel:
- A channel commanded off reports a low drain-source voltage, which indicates an open load.
- A channel commanded on reports overcurrent.
- A thermal flag counts in either state.

Every chip-select rise restarts a settling timer, and the comparators are ignored until it expires. Fault bits stay latched until the capture strobe at the start of the next read. On that strobe each bit clears unless its condition still holds at that moment.

Top module: `out_gate_supervisor`

## Requirements
- R1: On a cycle with `csRise` high, `cmdWord` is copied into the command latch. With `csRise` low, changes on `cmdWord` have no effect on `gate`. For a plain channel (not a PWM channel), `gate[i]` equals latch bit i whenever no blocking condition is present.
- R2: The demand for channel index `PWM_CH_LO` (default 4) is latch bit OR `pwmA`. The demand for index `PWM_CH_HI` (default 5) is latch bit OR `pwmB`. The PWM pins affect no other channel.
- R3: While `enable` is low, all `gate` bits are 0 and no fault bit is set. When `enable` returns high, `gate` again follows the latched command.
- R4: While `vpwrOv` is high, all `gate` bits are 0 and the command latch is kept. When it clears, the previous outputs return.
- R5: While `vddUv` is high, all `gate` bits are 0. The cycle after it is seen, the command latch and `fault` are both 0. A `csRise` during `vddUv` is ignored.
- R6: `overTemp[i]` forces `gate[i]` to 0 without touching any other channel. The channel turns on again when the flag drops if it is still demanded. A qualified `overTemp[i]` sets `fault[i]`.
- R7: For a channel whose demand is 0, `dsLow[i]` sets `fault[i]` and `overCur[i]` is ignored.
- R8: For a channel whose demand is 1, `overCur[i]` sets `fault[i]` and `dsLow[i]` is ignored.
- R9: Comparator inputs are qualified only on a clock edge that meets all of these conditions:
  - `SETTLE_CYCLES` edges have passed since the last edge that saw any of `csRise`, `enable` low, `vddUv` or `vpwrOv`;
  - none of those conditions is seen on that edge.

  As a result, a `csRise` at edge k first allows a fault at edge k+`SETTLE_CYCLES`+1, and a new `csRise` restarts the wait.
- R10: A fault bit stays 1 after its condition goes away. On a cycle with `capture` high, each bit takes the value of its qualified condition in that cycle.
- R11: After reset, `gate` and `fault` are 0 and the settling wait is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWord | input | NUM_CH | Command byte from the serial shift register, 1 = on |
| pwmA | input | 1 | Direct drive for channel PWM_CH_LO |
| pwmB | input | 1 | Direct drive for channel PWM_CH_HI |
| enable | input | 1 | Global output enable, active high |
| vddUv | input | 1 | Logic supply undervoltage flag |
| vpwrOv | input | 1 | Power supply overvoltage flag |
| overTemp | input | NUM_CH | Per-channel thermal shutdown flags |
| dsLow | input | NUM_CH | Per-channel drain-source below threshold |
| overCur | input | NUM_CH | Per-channel current limit flags |
| csRise | input | 1 | One-cycle strobe on chip-select rise |
| capture | input | 1 | One-cycle strobe on chip-select fall |
| gate | output | NUM_CH | Per-channel gate enable |
| fault | output | NUM_CH | Latched fault bits for readback |

## Verification
The bench builds the block with `SETTLE_CYCLES` set to 16 and keeps eight channels with the PWM pins on indices 4 and 5. The short window lets directed cases hit the exact edge where a held comparator result is first accepted, both after a single strobe and after a strobe repeated mid-window. It also lets random traffic, which has frequent strobes, enables and supply events, reach armed and unarmed states many times within a few hundred cycles.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

  // Strobes from the control half to the per-channel datapath.
  typedef struct packed {
    logic latchCmd;  // copy command word this cycle
    logic wipe;      // supply reset: clear latch and faults
    logic sweep;     // readback capture: refresh fault bits
    logic armed;     // comparators qualified this cycle
    logic allowOut;  // no global condition blocks the gates
  } ctlStrobe_t;

endpackage

// File: rtl/fsup_ctrl.sv
module fsup_ctrl #(
  parameter int SETTLE_CYCLES = 12500
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csRise,
  input  logic                  capture,
  input  logic                  enable,
  input  logic                  vddUv,
  input  logic                  vpwrOv,
  output fsup_pkg::ctlStrobe_t  strobe
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES);

  logic [CNT_W-1:0] settleCnt;
  logic             reload;
  logic             supplyBad;

  assign supplyBad = vddUv | vpwrOv;
  assign reload    = csRise | ~enable | supplyBad;

  // Settling timer: reloaded by any event that disturbs the outputs,
  // counts down to zero, and holds there.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      settleCnt <= CNT_LOAD;
    end else if (reload) begin
      settleCnt <= CNT_LOAD;
    end else if (settleCnt != '0) begin
      settleCnt <= settleCnt - CNT_W'(1);
    end
  end

  always_comb begin
    strobe.latchCmd = csRise & ~vddUv;
    strobe.wipe     = vddUv;
    strobe.sweep    = capture & ~vddUv;
    strobe.armed    = (settleCnt == '0) & ~reload;
    strobe.allowOut = enable & ~supplyBad;
  end

  AST_RELOAD_ON_CS: assert property (@(posedge clk) disable iff (!rstN)
    csRise |=> settleCnt == CNT_LOAD);  // R9

  AST_SETTLE_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (!reload && settleCnt != '0) |=> settleCnt == $past(settleCnt) - CNT_W'(1));  // R9

endmodule

// File: rtl/fsup_datapath.sv
module fsup_datapath #(
  parameter int NUM_CH    = 8,
  parameter int PWM_CH_LO = 4,
  parameter int PWM_CH_HI = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fsup_pkg::ctlStrobe_t  strobe,
  input  logic [NUM_CH-1:0]     cmdWord,
  input  logic                  pwmA,
  input  logic                  pwmB,
  input  logic [NUM_CH-1:0]     overTemp,
  input  logic [NUM_CH-1:0]     dsLow,
  input  logic [NUM_CH-1:0]     overCur,
  output logic [NUM_CH-1:0]     gate,
  output logic [NUM_CH-1:0]     fault
);

  logic [NUM_CH-1:0] cmdLatch;
  logic [NUM_CH-1:0] demand;
  logic [NUM_CH-1:0] faultCond;
  logic [NUM_CH-1:0] faultReg;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCh
    if (ch == PWM_CH_LO) begin : gPwmLo
      assign demand[ch] = cmdLatch[ch] | pwmA;
    end else if (ch == PWM_CH_HI) begin : gPwmHi
      assign demand[ch] = cmdLatch[ch] | pwmB;
    end else begin : gPlain
      assign demand[ch] = cmdLatch[ch];
    end

    // Thermal flag blocks only its own channel.
    assign gate[ch] = demand[ch] & strobe.allowOut & ~overTemp[ch];

    // Meaning of the comparators depends on the demanded state.
    assign faultCond[ch] = strobe.armed &
                           (overTemp[ch] | (demand[ch] ? overCur[ch] : dsLow[ch]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdLatch <= '0;
    end else if (strobe.wipe) begin
      cmdLatch <= '0;
    end else if (strobe.latchCmd) begin
      cmdLatch <= cmdWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultReg <= '0;
    end else if (strobe.wipe) begin
      faultReg <= '0;
    end else if (strobe.sweep) begin
      faultReg <= faultCond;
    end else begin
      faultReg <= faultReg | faultCond;
    end
  end

  assign fault = faultReg;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.latchCmd && !strobe.wipe) |=> $stable(cmdLatch));  // R1

  AST_WIPE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wipe |=> (cmdLatch == '0 && faultReg == '0));  // R5

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.sweep && !strobe.wipe) |=> ((faultReg & $past(faultReg)) == $past(faultReg)));  // R10

  AST_QUIET_UNARMED: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.armed && !strobe.sweep && !strobe.wipe) |=> $stable(faultReg));  // R9

endmodule

// File: rtl/out_gate_supervisor.sv
module out_gate_supervisor #(
  parameter int NUM_CH        = 8,
  parameter int PWM_CH_LO     = 4,
  parameter int PWM_CH_HI     = 5,
  parameter int SETTLE_CYCLES = 12500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] cmdWord,
  input  logic              pwmA,
  input  logic              pwmB,
  input  logic              enable,
  input  logic              vddUv,
  input  logic              vpwrOv,
  input  logic [NUM_CH-1:0] overTemp,
  input  logic [NUM_CH-1:0] dsLow,
  input  logic [NUM_CH-1:0] overCur,
  input  logic              csRise,
  input  logic              capture,
  output logic [NUM_CH-1:0] gate,
  output logic [NUM_CH-1:0] fault
);

  fsup_pkg::ctlStrobe_t strobe;

  fsup_ctrl #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csRise  (csRise),
    .capture (capture),
    .enable  (enable),
    .vddUv   (vddUv),
    .vpwrOv  (vpwrOv),
    .strobe  (strobe)
  );

  fsup_datapath #(
    .NUM_CH    (NUM_CH),
    .PWM_CH_LO (PWM_CH_LO),
    .PWM_CH_HI (PWM_CH_HI)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdWord  (cmdWord),
    .pwmA     (pwmA),
    .pwmB     (pwmB),
    .overTemp (overTemp),
    .dsLow    (dsLow),
    .overCur  (overCur),
    .gate     (gate),
    .fault    (fault)
  );

endmodule

// File: tb/test_out_gate_supervisor.sv
`timescale 1ns/1ps
module test_out_gate_supervisor;

  localparam int S = 16;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] cmdWord, overTemp, dsLow, overCur, gate, fault;
  logic       pwmA, pwmB, enable, vddUv, vpwrOv, csRise, capture;

  int nChecks = 0;
  int nErr    = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  out_gate_supervisor #(.SETTLE_CYCLES(S)) i_out_gate_supervisor (
    .clk(clk), .rstN(rstN), .cmdWord(cmdWord), .pwmA(pwmA), .pwmB(pwmB),
    .enable(enable), .vddUv(vddUv), .vpwrOv(vpwrOv), .overTemp(overTemp),
    .dsLow(dsLow), .overCur(overCur), .csRise(csRise), .capture(capture),
    .gate(gate), .fault(fault)
  );

  // ---- reference functions built from the requirements ----
  function automatic logic [7:0] wantF(input logic [7:0] c, input logic a, input logic b);
    logic [7:0] w;
    w = c;
    w[4] = w[4] | a;
    w[5] = w[5] | b;
    return w;
  endfunction

  function automatic logic [7:0] expGateF(input logic [7:0] c, input logic a, input logic b,
                                          input logic en, input logic ov, input logic uv,
                                          input logic [7:0] ot);
    if (!en || ov || uv) return 8'h00;
    return wantF(c, a, b) & ~ot;
  endfunction

  function automatic logic [7:0] condF(input logic [7:0] c, input logic a, input logic b,
                                       input logic [7:0] ot, input logic [7:0] ds,
                                       input logic [7:0] oc);
    logic [7:0] w;
    w = wantF(c, a, b);
    return ot | (w & oc) | (~w & ds);
  endfunction

  // ---- cycle model of latch, timer and fault register ----
  logic [7:0] mCmd, mFault, det;
  int         mCnt;

  always @(posedge clk) begin
    if (!rstN) begin
      mCmd <= 8'h00; mFault <= 8'h00; mCnt <= S;
    end else begin
      det = (mCnt == 0 && enable && !vddUv && !vpwrOv && !csRise) ?
            condF(mCmd, pwmA, pwmB, overTemp, dsLow, overCur) : 8'h00;
      if (vddUv) begin
        mCmd <= 8'h00; mFault <= 8'h00;
      end else begin
        mFault <= capture ? det : (mFault | det);
        if (csRise) mCmd <= cmdWord;
      end
      mCnt <= (csRise || !enable || vddUv || vpwrOv) ? S : ((mCnt > 0) ? mCnt - 1 : 0);
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseCs();
    csRise = 1'b1; step(1); csRise = 1'b0;
  endtask

  task automatic pulseCap();
    capture = 1'b1; step(1); capture = 1'b0;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; cmdWord = 8'h00; pwmA = 1'b0; pwmB = 1'b0; enable = 1'b1;
    vddUv = 1'b0; vpwrOv = 1'b0; overTemp = 8'h00; dsLow = 8'hFF; overCur = 8'h00;
    csRise = 1'b0; capture = 1'b0;
    step(3);
    rstN = 1'b1;
    step(1);
    chk("R11 gate after reset", gate, 8'h00);
    chk("R11 fault held off during settle", fault, 8'h00);
    dsLow = 8'h00;
    step(S + 4);
    chk("R11 fault after settle with no condition", fault, 8'h00);

    // R1 command latch
    cmdWord = 8'hA5; step(2);
    chk("R1 live cmdWord ignored", gate, 8'h00);
    pulseCs();
    chk("R1 latched command drives gate", gate, 8'hA5);
    cmdWord = 8'h00; step(2);
    chk("R1 latch holds", gate, 8'hA5);

    // R2 PWM OR
    pwmA = 1'b1; step(1);
    chk("R2 pwmA ORs into index 4", gate, 8'hB5);
    pwmA = 1'b0; pulseCs();
    pwmB = 1'b1; step(1);
    chk("R2 pwmB drives index 5 only", gate, 8'h20);
    pwmB = 1'b0; pwmA = 1'b1; step(1);
    chk("R2 pwmA drives index 4 only", gate, 8'h10);
    pwmA = 1'b0;

    // R4 overvoltage
    cmdWord = 8'h3C; pulseCs();
    vpwrOv = 1'b1; step(1);
    chk("R4 overvoltage blocks all", gate, 8'h00);
    vpwrOv = 1'b0; step(1);
    chk("R4 outputs restored", gate, 8'h3C);

    // R6 thermal
    overTemp = 8'h04; step(1);
    chk("R6 only hot channel off", gate, 8'h38);
    step(S + 3);
    chk("R6 thermal fault latched", fault, 8'h04);
    overTemp = 8'h00; step(1);
    chk("R6 channel back on after cooling", gate, 8'h3C);
    chk("R10 fault sticky after cooling", fault, 8'h04);
    pulseCap();
    chk("R10 capture clears gone condition", fault, 8'h00);

    // R7 / R8 meaning by demanded state (cmd 0x3C)
    dsLow = 8'h09; overCur = 8'h12; step(2);
    chk("R7 R8 off open-load and on overcurrent", fault, 8'h11);
    overCur = 8'h00; step(1);
    chk("R10 still latched", fault, 8'h11);
    pulseCap();
    chk("R10 capture keeps present condition", fault, 8'h01);
    dsLow = 8'h00; pulseCap();
    chk("R10 capture with nothing present", fault, 8'h00);

    // R3 enable
    enable = 1'b0; dsLow = 8'h01; step(S + 4);
    chk("R3 enable low blocks gates", gate, 8'h00);
    chk("R3 detection suspended", fault, 8'h00);
    dsLow = 8'h00; enable = 1'b1; step(1);
    chk("R3 outputs resume", gate, 8'h3C);
    step(S + 2);

    // R9 settle window boundary
    dsLow = 8'h01; pulseCs();
    step(S);
    chk("R9 ignored through last settle edge", fault, 8'h00);
    step(1);
    chk("R9 accepted on first armed edge", fault, 8'h01);
    dsLow = 8'h00; pulseCap();
    dsLow = 8'h01; pulseCs();
    step(8);
    pulseCs();
    step(S);
    chk("R9 restart extends window", fault, 8'h00);
    step(1);
    chk("R9 accepted after restarted window", fault, 8'h01);

    // R5 undervoltage
    vddUv = 1'b1; step(1);
    chk("R5 undervoltage blocks gates", gate, 8'h00);
    chk("R5 undervoltage clears faults", fault, 8'h00);
    cmdWord = 8'hFF; pulseCs();
    vddUv = 1'b0; dsLow = 8'h00; step(1);
    chk("R5 latch cleared and cs ignored", gate, 8'h00);
    chk("R5 faults stay clear", fault, 8'h00);

    // random traffic against the model (R1..R10)
    for (int i = 0; i < 600; i++) begin
      chk("R1-gate model", gate, expGateF(mCmd, pwmA, pwmB, enable, vpwrOv, vddUv, overTemp));
      chk("R10-fault model", fault, mFault);
      cmdWord  = 8'($urandom);
      pwmA     = 1'($urandom);
      pwmB     = 1'($urandom);
      csRise   = ($urandom % 16) == 0;
      capture  = ($urandom % 8) == 0;
      enable   = ($urandom % 20) != 0;
      vpwrOv   = ($urandom % 25) == 0;
      vddUv    = ($urandom % 60) == 0;
      overTemp = 8'($urandom & $urandom & $urandom);
      dsLow    = 8'($urandom & $urandom);
      overCur  = 8'($urandom & $urandom);
      step(1);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule